// File: doc/BRIEF.md
# Retire-Count Decrementer with Interrupt Entry

This block is a 64-bit down-counter that steps once for every instruction the core retires. While the count is nonzero, each retirement lowers it by one. A retirement that finds the count already at zero does not wrap the counter. Instead it raises a pending interrupt. That request stays raised until the pipeline signals that it can take an interrupt.

When the interrupt is taken, the block builds the register updates for interrupt entry in one step and presents them for one cycle under a single strobe:
- the interrupted instruction address, for the first save register;
- a masked copy of the machine state, for the second save register;
- a new machine state with selected bits cleared;
- the fixed vector address, 0x900, as the new program counter.

In the same step the counter re-arms itself to all ones. Software can read the count at any time and can overwrite it.

Top module: `dec_timer_irq`

## Requirements
- R1: Reset (synchronous, active high) sets the count to all ones and clears the pending flag and the take strobe.
- R2: In a cycle with `retire_i` high, no software write, no take, and a nonzero count, the count drops by exactly one.
- R3: In a cycle with `retire_i` high, no software write and no take, a count of zero sets `pending_o`. The count stays at zero.
- R4: A take happens in any cycle where `pending_o` and `accept_i` are both high. On the next cycle `take_o` is high for exactly one cycle, and `save0_o` holds the `pc_i` value from the take cycle.
- R5: During a take strobe, `save1_o` equals the `msr_i` value from the take cycle ANDed with 0xFFFFFFFF78FC0FFF.
- R6: During a take strobe, `msr_o` equals the `msr_i` value from the take cycle ANDed with 0xFFFFFFFFFFFF76CD.
- R7: During a take strobe, `npc_o` equals 0x900.
- R8: After a take with no software write, the count is all ones and `pending_o` is low. A retirement in the take cycle does not decrement.
- R9: A software write loads `sw_wdata_i` into the count, ahead of any decrement or re-arm in the same cycle. A write of a nonzero value clears `pending_o`, and so does a write in a take cycle.
- R10: While `pending_o` is high and `accept_i` is low, `pending_o` stays high. This holds through retirements and through a software write of zero.
- R11: `rd_data_o` always shows the current count, one cycle after the edge that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| sw_wr_i | input | 1 | Software write strobe for the count |
| sw_wdata_i | input | 64 | Software write value |
| rd_data_o | output | 64 | Current count (software read) |
| pending_o | output | 1 | Decrementer interrupt pending |
| accept_i | input | 1 | Pipeline can take an interrupt this cycle |
| pc_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Current machine state |
| take_o | output | 1 | One-cycle strobe: entry updates valid |
| save0_o | output | 64 | Saved instruction address |
| save1_o | output | 64 | Saved masked machine state |
| msr_o | output | 64 | New machine state |
| npc_o | output | 64 | New program counter (vector) |

## Verification
Every result of this block appears one clock edge after the stimulus that causes it. The count, the pending flag and the entry payload all come from a single register stage. After the edge where retire, write or accept is applied, the new count and pending flag are visible. After the edge of the take cycle, `take_o` and the entry values are visible. The bench drives inputs just after a rising edge, lets one edge pass, then samples 1 ns later. Each check therefore compares the state that the preceding cycle's inputs should produce. Payload values are compared against `pc_i` and `msr_i` as they were driven in the take cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int unsigned DEC_XLEN = 64;
  localparam logic [63:0] DEC_SAVE_MASK = 64'hFFFF_FFFF_78FC_0FFF;
  localparam logic [63:0] DEC_STATE_MASK = 64'hFFFF_FFFF_FFFF_76CD;
  localparam logic [63:0] DEC_VECTOR = 64'h0000_0000_0000_0900;

  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_LOAD   = 2'd1,
    CNT_REARM  = 2'd2,
    CNT_DEC    = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    retire_i,
  input  logic    wr_i,
  input  logic    wdata_nz_i,
  input  logic    cnt_zero_i,
  input  logic    accept_i,
  output cnt_op_e op_o,
  output logic    fire_o,
  output logic    pend_o
);
  logic pend_q, pend_d;
  logic fire;

  assign fire = pend_q & accept_i;

  // Priority: software write, then take/re-arm, then retirement.
  always_comb begin
    op_o   = CNT_HOLD;
    pend_d = pend_q;
    if (wr_i) begin
      op_o = CNT_LOAD;
      if (wdata_nz_i || fire) pend_d = 1'b0;
    end else if (fire) begin
      op_o   = CNT_REARM;
      pend_d = 1'b0;
    end else if (retire_i) begin
      if (cnt_zero_i) pend_d = 1'b1;
      else            op_o   = CNT_DEC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end

  assign fire_o = fire;
  assign pend_o = pend_q;

  p_expire_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !wr_i && !fire && cnt_zero_i) |=> pend_q);

  p_take_clears_r8: assert property (@(posedge clk) disable iff (rst)
    fire |=> !pend_q);

  p_stall_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !accept_i && !(wr_i && wdata_nz_i)) |=> pend_q);
endmodule

// File: rtl/dec_counter.sv
module dec_counter
  import dec_pkg::*;
#(
  parameter int unsigned XLEN = DEC_XLEN
) (
  input  logic            clk,
  input  logic            rst,
  input  cnt_op_e         op_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] cnt_o,
  output logic            zero_o
);
  localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};
  localparam logic [XLEN-1:0] ONE      = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ALL_ONES;
    end else begin
      case (op_i)
        CNT_LOAD:  cnt_q <= wdata_i;
        CNT_REARM: cnt_q <= ALL_ONES;
        CNT_DEC:   cnt_q <= cnt_q - ONE;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == CNT_LOAD) |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/dec_entry.sv
module dec_entry
  import dec_pkg::*;
#(
  parameter int unsigned     XLEN       = DEC_XLEN,
  parameter logic [XLEN-1:0] SAVE_MASK  = DEC_SAVE_MASK,
  parameter logic [XLEN-1:0] STATE_MASK = DEC_STATE_MASK,
  parameter logic [XLEN-1:0] VECTOR     = DEC_VECTOR
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] msr_i,
  output logic            take_o,
  output logic [XLEN-1:0] save0_o,
  output logic [XLEN-1:0] save1_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] npc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      take_o  <= 1'b0;
      save0_o <= '0;
      save1_o <= '0;
      msr_o   <= '0;
      npc_o   <= '0;
    end else begin
      take_o <= fire_i;
      if (fire_i) begin
        save0_o <= pc_i;
        save1_o <= msr_i & SAVE_MASK;
        msr_o   <= msr_i & STATE_MASK;
        npc_o   <= VECTOR;
      end
    end
  end

  p_save_pc_r4: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> (take_o && save0_o == $past(pc_i)));

  p_state_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((msr_o & ~STATE_MASK) == '0));
endmodule

// File: rtl/dec_timer_irq.sv
module dec_timer_irq
  import dec_pkg::*;
#(
  parameter int unsigned     XLEN       = DEC_XLEN,
  parameter logic [XLEN-1:0] SAVE_MASK  = DEC_SAVE_MASK,
  parameter logic [XLEN-1:0] STATE_MASK = DEC_STATE_MASK,
  parameter logic [XLEN-1:0] VECTOR     = DEC_VECTOR
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            retire_i,
  input  logic            sw_wr_i,
  input  logic [XLEN-1:0] sw_wdata_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic            pending_o,
  input  logic            accept_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] msr_i,
  output logic            take_o,
  output logic [XLEN-1:0] save0_o,
  output logic [XLEN-1:0] save1_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] npc_o
);
  cnt_op_e op;
  logic    fire;
  logic    cnt_zero;

  dec_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .retire_i   (retire_i),
    .wr_i       (sw_wr_i),
    .wdata_nz_i (sw_wdata_i != '0),
    .cnt_zero_i (cnt_zero),
    .accept_i   (accept_i),
    .op_o       (op),
    .fire_o     (fire),
    .pend_o     (pending_o)
  );

  dec_counter #(.XLEN(XLEN)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op),
    .wdata_i (sw_wdata_i),
    .cnt_o   (rd_data_o),
    .zero_o  (cnt_zero)
  );

  dec_entry #(
    .XLEN       (XLEN),
    .SAVE_MASK  (SAVE_MASK),
    .STATE_MASK (STATE_MASK),
    .VECTOR     (VECTOR)
  ) u_entry (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .pc_i    (pc_i),
    .msr_i   (msr_i),
    .take_o  (take_o),
    .save0_o (save0_o),
    .save1_o (save1_o),
    .msr_o   (msr_o),
    .npc_o   (npc_o)
  );

  p_decrement_r2: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !sw_wr_i && !(pending_o && accept_i) && rd_data_o != '0)
      |=> rd_data_o == $past(rd_data_o) - 1'b1);

  p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
    (pending_o && accept_i && !sw_wr_i) |=> (rd_data_o == {XLEN{1'b1}} && !pending_o));

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);

  p_vector_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(take_o) |-> npc_o == VECTOR);
endmodule

// File: tb/tb_dec_timer_irq.sv
module tb_dec_timer_irq;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] M1   = 64'hFFFF_FFFF_78FC_0FFF;
  localparam logic [63:0] M2   = 64'hFFFF_FFFF_FFFF_76CD;
  localparam logic [63:0] VEC  = 64'h900;

  typedef struct packed {
    logic        wr;
    logic [63:0] wd;
    logic        ret;
    logic        acc;
    logic [63:0] pc;
    logic [63:0] msr;
    logic [63:0] ecnt;
    logic        epend;
    logic        etake;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b1, 64'd3, 1'b0, 1'b0, 64'h0, 64'h0, 64'd3, 1'b0, 1'b0},
    '{1'b0, 64'd0, 1'b1, 1'b0, 64'h0, 64'h0, 64'd2, 1'b0, 1'b0},
    '{1'b0, 64'd0, 1'b1, 1'b1, 64'h0, 64'h0, 64'd1, 1'b0, 1'b0},
    '{1'b0, 64'd0, 1'b1, 1'b0, 64'h0, 64'h0, 64'd0, 1'b0, 1'b0},
    '{1'b0, 64'd0, 1'b1, 1'b0, 64'h0, 64'h0, 64'd0, 1'b1, 1'b0},
    '{1'b0, 64'd0, 1'b1, 1'b0, 64'h0, 64'h0, 64'd0, 1'b1, 1'b0},
    '{1'b0, 64'd0, 1'b1, 1'b1, 64'h1234, 64'hFFFF_FFFF_FFFF_FFFF,
      64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1},
    '{1'b0, 64'd0, 1'b1, 1'b0, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0},
    '{1'b1, 64'd0, 1'b0, 1'b0, 64'h0, 64'h0, 64'd0, 1'b0, 1'b0},
    '{1'b0, 64'd0, 1'b1, 1'b0, 64'h0, 64'h0, 64'd0, 1'b1, 1'b0},
    '{1'b1, 64'd5, 1'b1, 1'b0, 64'h0, 64'h0, 64'd5, 1'b0, 1'b0},
    '{1'b1, 64'd7, 1'b1, 1'b0, 64'h0, 64'h0, 64'd7, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_i = 1'b0;
  logic        sw_wr_i = 1'b0;
  logic [63:0] sw_wdata_i = '0;
  logic        accept_i = 1'b0;
  logic [63:0] pc_i = '0;
  logic [63:0] msr_i = '0;
  logic [63:0] rd_data_o, save0_o, save1_o, msr_o, npc_o;
  logic        pending_o, take_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dec_timer_irq dut (
    .clk(clk), .rst(rst), .retire_i(retire_i), .sw_wr_i(sw_wr_i),
    .sw_wdata_i(sw_wdata_i), .rd_data_o(rd_data_o), .pending_o(pending_o),
    .accept_i(accept_i), .pc_i(pc_i), .msr_i(msr_i), .take_o(take_o),
    .save0_o(save0_o), .save1_o(save1_o), .msr_o(msr_o), .npc_o(npc_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [63:0] wd, input logic ret,
                       input logic acc, input logic [63:0] pc, input logic [63:0] msr);
    sw_wr_i = wr; sw_wdata_i = wd; retire_i = ret; accept_i = acc;
    pc_i = pc; msr_i = msr;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 64'd0, 1'b0, 1'b0, 64'd0, 64'd0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] m;
    rst = 1'b1;
    idle(); idle();
    chk("R1 count", rd_data_o, ONES);
    chk("R1 pending", {63'd0, pending_o}, 64'd0);
    chk("R1 take", {63'd0, take_o}, 64'd0);
    rst = 1'b0;

    // Vector walk: R2 R3 R4 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].wr, VT[i].wd, VT[i].ret, VT[i].acc, VT[i].pc, VT[i].msr);
      chk($sformatf("R11/R2/R9 count step %0d", i), rd_data_o, VT[i].ecnt);
      chk($sformatf("R3/R10 pending step %0d", i), {63'd0, pending_o}, {63'd0, VT[i].epend});
      chk($sformatf("R4 take step %0d", i), {63'd0, take_o}, {63'd0, VT[i].etake});
      if (VT[i].etake) begin
        chk("R4 save0", save0_o, VT[i].pc);
        chk("R5 save1", save1_o, VT[i].msr & M1);
        chk("R6 msr", msr_o, VT[i].msr & M2);
        chk("R7 npc", npc_o, VEC);
      end
    end

    // Second take with a distinct state pattern: R4 R5 R6 R7
    drive(1'b1, 64'd0, 1'b0, 1'b0, 64'd0, 64'd0);
    drive(1'b0, 64'd0, 1'b1, 1'b0, 64'd0, 64'd0);
    chk("R3 pending set", {63'd0, pending_o}, 64'd1);
    m = 64'h0123_4567_89AB_CDEF;
    drive(1'b0, 64'd0, 1'b0, 1'b1, 64'hDEAD_BEEF_0000_1000, m);
    chk("R4 take", {63'd0, take_o}, 64'd1);
    chk("R4 save0", save0_o, 64'hDEAD_BEEF_0000_1000);
    chk("R5 save1", save1_o, m & M1);
    chk("R6 msr", msr_o, m & M2);
    chk("R7 npc", npc_o, VEC);
    chk("R8 rearm", rd_data_o, ONES);
    idle();
    chk("R4 one cycle", {63'd0, take_o}, 64'd0);

    // Write in a take cycle: R9
    drive(1'b1, 64'd0, 1'b0, 1'b0, 64'd0, 64'd0);
    drive(1'b0, 64'd0, 1'b1, 1'b0, 64'd0, 64'd0);
    drive(1'b1, 64'd9, 1'b1, 1'b1, 64'h40, 64'd0);
    chk("R9 take still fires", {63'd0, take_o}, 64'd1);
    chk("R9 write beats rearm", rd_data_o, 64'd9);
    chk("R9 pending cleared", {63'd0, pending_o}, 64'd0);

    // Zero write while pending and stalled: R10
    drive(1'b1, 64'd0, 1'b0, 1'b0, 64'd0, 64'd0);
    drive(1'b0, 64'd0, 1'b1, 1'b0, 64'd0, 64'd0);
    drive(1'b1, 64'd0, 1'b1, 1'b0, 64'd0, 64'd0);
    chk("R10 zero write keeps pending", {63'd0, pending_o}, 64'd1);
    chk("R10 count", rd_data_o, 64'd0);

    // Mid-run reset: R1
    rst = 1'b1;
    idle();
    rst = 1'b0;
    chk("R1 count after reset", rd_data_o, ONES);
    chk("R1 pending after reset", {63'd0, pending_o}, 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule